// File: doc/BRIEF.md
# Level-Sensitive Scan Latch Chain

This block holds a chain of scan storage cells that takes the place of the ordinary latches in a sequential circuit. Each cell has a front latch (L1) and a back latch (L2). In normal operation L1 is a plain latch: while the system clock is high it follows the system data input, and its value drives the cell's data output. In test mode two separate scan clocks, A and B, are pulsed one after the other. A moves each cell's scan input into its L1. B then copies L1 into L2. The L2 of each cell drives the scan input of the next cell. Together the cells form one serial register, so known values can be loaded into the internal nodes and captured node values can be read out.

The latches are modelled on a fast sampling clock `clk_i`. The three level-sensitive controls (system clock, A, B) are decoded into one phase for each sampling cycle. A latch that is open takes its input on every sampling edge while its control stays high. The controls must never be high together. If two of them overlap, the block freezes every latch and raises a protocol-error flag. The chain length is the parameter `N`.

Top module: `scan_latch_chain`

## Requirements
- R1: While `rst_ni` is low, every L1 and every L2 is cleared, so `data_o` and `scan_out_o` read zero after reset.
- R2: While the system clock is high and A and B are low, every L1 follows its `data_i` bit. `data_o` shows the captured value on the sampling edge after the data was sampled.
- R3: While all three controls are low, `data_o` and `scan_out_o` hold their values, whatever `data_i` and `scan_in_i` do.
- R4: While A alone is high, L1 of cell i takes L2 of cell i-1, and L1 of cell 0 takes `scan_in_i`. `scan_out_o` does not change.
- R5: While B alone is high, every L2 copies its own L1 and `data_o` does not change. L2 changes only in this phase.
- R6: Unload order: after a capture and one B pulse, `scan_out_o` shows captured bit N-1. Each A-then-B pulse pair that follows presents the next lower bit index, so all N captured bits appear, with bit N-1 first.
- R7: Load order: after N A-then-B pulse pairs in which scan_in carries bits s0..s(N-1), `data_o[N-1-k]` equals sk and `scan_out_o` equals s0.
- R8: `proto_err_o` is high in the sampling cycle after an edge at which two or more of system clock, A and B were high. It is low after an edge at which at most one of them was high.
- R9: On any sampling edge where two or more controls are high, no L1 or L2 changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock that models the latch levels |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_clk_i | input | 1 | System clock level; opens L1 to `data_i` |
| scan_a_i | input | 1 | Scan clock A level; opens L1 to the scan input |
| scan_b_i | input | 1 | Scan clock B level; opens L2 to L1 |
| scan_in_i | input | 1 | Serial input to the scan input of cell 0 |
| data_i | input | N | System data input, one bit per cell |
| data_o | output | N | L1 value of each cell |
| scan_out_o | output | 1 | L2 value of cell N-1 |
| proto_err_o | output | 1 | Registered flag: controls overlapped on the last edge |

## Verification
The cell assertions assume that the three controls are level signals that stay stable across the sampling edges, and that a correct sequence never opens two of them at once. Only the overlap checks cover the case where two are open. The stimulus changes every control and data input on the falling edge of the sampling clock. It holds each pulse for two sampling cycles and leaves an idle cycle between pulses. Overlaps are created only on purpose, in directed cases, and the freeze and flag behaviour is checked there.

// File: rtl/slc_pkg.sv
package slc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SYS  = 3'd1,
    PH_A    = 3'd2,
    PH_B    = 3'd3,
    PH_BAD  = 3'd4
  } slc_phase_e;

  function automatic slc_phase_e decode_phase(input logic sys_clk, input logic a, input logic b);
    unique case ({sys_clk, a, b})
      3'b000:  return PH_IDLE;
      3'b100:  return PH_SYS;
      3'b010:  return PH_A;
      3'b001:  return PH_B;
      default: return PH_BAD;
    endcase
  endfunction
endpackage

// File: rtl/slc_clk_guard.sv
module slc_clk_guard
  import slc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sys_clk_i,
  input  logic       a_i,
  input  logic       b_i,
  output slc_phase_e phase_o,
  output logic       err_o
);
  assign phase_o = decode_phase(sys_clk_i, a_i, b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_o <= 1'b0;
    else         err_o <= (phase_o == PH_BAD);
  end

  AST_OVERLAP_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({sys_clk_i, a_i, b_i}) > 1) |=> err_o); // R8
  AST_NO_FALSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones({sys_clk_i, a_i, b_i}) <= 1) |=> !err_o); // R8
endmodule

// File: rtl/slc_cell.sv
module slc_cell
  import slc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  slc_phase_e phase_i,
  input  logic       d_i,
  input  logic       si_i,
  output logic       l1_o,
  output logic       l2_o
);
  logic l1_q, l2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      l1_q <= 1'b0;
      l2_q <= 1'b0;
    end else begin
      unique case (phase_i)
        PH_SYS:  l1_q <= d_i;
        PH_A:    l1_q <= si_i;
        PH_B:    l2_q <= l1_q;
        default: ;
      endcase
    end
  end

  assign l1_o = l1_q;
  assign l2_o = l2_q;

  AST_L2_ONLY_ON_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_B) |=> $stable(l2_o)); // R5
  AST_L1_ONLY_ON_SYS_OR_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i != PH_SYS && phase_i != PH_A) |=> $stable(l1_o)); // R3
  AST_A_LOADS_SCAN_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_A) |=> (l1_o == $past(si_i))); // R4
  AST_B_COPIES_L1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_B) |=> (l2_o == $past(l1_o))); // R5
  AST_OVERLAP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == PH_BAD) |=> ($stable(l1_o) && $stable(l2_o))); // R9
endmodule

// File: rtl/scan_latch_chain.sv
module scan_latch_chain
  import slc_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sys_clk_i,
  input  logic         scan_a_i,
  input  logic         scan_b_i,
  input  logic         scan_in_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] data_o,
  output logic         scan_out_o,
  output logic         proto_err_o
);
  localparam int LAST = N - 1;

  slc_phase_e phase;
  logic [N-1:0] l1, l2, si;

  slc_clk_guard u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sys_clk_i (sys_clk_i),
    .a_i       (scan_a_i),
    .b_i       (scan_b_i),
    .phase_o   (phase),
    .err_o     (proto_err_o)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    if (i == 0) begin : g_head
      assign si[i] = scan_in_i;
    end else begin : g_link
      assign si[i] = l2[i-1];
    end
    slc_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .phase_i (phase),
      .d_i     (data_i[i]),
      .si_i    (si[i]),
      .l1_o    (l1[i]),
      .l2_o    (l2[i])
    );
  end

  assign data_o     = l1;
  assign scan_out_o = l2[LAST];

  AST_SCAN_OUT_ONLY_ON_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scan_b_i || sys_clk_i || scan_a_i) |=> $stable(scan_out_o)); // R4
endmodule

// File: tb/sim_scan_latch_chain.sv
module sim_scan_latch_chain;
  localparam int N = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sysc = 0, sa = 0, sb = 0, sin = 0;
  logic [N-1:0] din = '0, dout;
  logic sout, perr;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  scan_latch_chain #(.N(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sys_clk_i(sysc), .scan_a_i(sa), .scan_b_i(sb),
    .scan_in_i(sin), .data_i(din), .data_o(dout), .scan_out_o(sout), .proto_err_o(perr)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // bits s0..s(N-1) shifted in: bit N-1-k ends up holding s_k
  function automatic logic [N-1:0] load_image(logic [N-1:0] seq);
    logic [N-1:0] r;
    for (int k = 0; k < N; k++) r[N-1-k] = seq[k];
    return r;
  endfunction

  task automatic pulse(int which);
    @(negedge clk);
    case (which)
      0: sysc = 1;
      1: sa = 1;
      default: sb = 1;
    endcase
    repeat (2) @(negedge clk);
    sysc = 0; sa = 0; sb = 0;
    @(negedge clk);
  endtask

  task automatic load(logic [N-1:0] seq);
    for (int k = 0; k < N; k++) begin
      sin = seq[k];
      pulse(1);
      pulse(2);
    end
  endtask

  task automatic capture_unload(logic [N-1:0] d);
    din = d;
    pulse(0);
    chk("R2 capture", dout, d);
    din = ~d;
    pulse(2);
    chk("R6 first out", sout, d[N-1]);
    for (int k = 1; k < N; k++) begin
      sin = 1'($urandom);
      pulse(1);
      pulse(2);
      chk("R6 unload", sout, d[N-1-k]);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v, d;
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset data", dout, '0);
    chk("R1 reset sout", sout, 0);
    chk("R8 no err after reset", perr, 0);

    // R2 capture and R3 hold
    din = 8'hA5;
    pulse(0);
    chk("R2 capture", dout, 8'hA5);
    din = 8'h3C; sin = 1;
    repeat (3) @(negedge clk);
    chk("R3 hold data", dout, 8'hA5);
    chk("R3 hold sout", sout, 0);

    // R7 load, then R4/R5 single pulses
    v = 8'b1011_0010;
    load(v);
    chk("R7 load image", dout, load_image(v));
    chk("R7 sout", sout, v[0]);
    v = load_image(v);
    d = 8'h5A; din = d;
    pulse(0);
    sin = 1;
    pulse(1);
    chk("R4 A shift L1", dout, {v[N-2:0], 1'b1});
    chk("R4 sout unchanged", sout, v[N-1]);
    pulse(2);
    chk("R5 B keeps data", dout, {v[N-2:0], 1'b1});
    chk("R5 B copies", sout, v[N-2]);

    // R8/R9 overlap
    d = dout;
    @(negedge clk);
    sysc = 1; sa = 1; din = ~d; sin = ~sin;
    @(negedge clk);
    chk("R8 err on overlap", perr, 1);
    chk("R9 frozen data", dout, d);
    sysc = 0; sb = 1;
    @(negedge clk);
    chk("R9 frozen sout", sout, v[N-2]);
    sa = 0; sb = 0;
    @(negedge clk);
    chk("R8 err clears", perr, 0);
    chk("R9 frozen data after", dout, d);

    // directed unload corners and random rounds
    capture_unload('0);
    capture_unload('1);
    capture_unload(8'h81);
    for (int r = 0; r < 6; r++) begin
      capture_unload(N'($urandom));
      v = N'($urandom);
      load(v);
      chk("R7 random load", dout, load_image(v));
    end

    // R1 reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R1 mid reset data", dout, '0);
    chk("R1 mid reset sout", sout, 0);
    rst_n = 1;

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule